// File: doc/BRIEF.md
# Constant Off-Time PWM Current Limiter

This block sits between a three-phase commutation sequencer and the gate drivers of a motor bridge. It passes the sequencer's high-side and low-side enable patterns to the gates. It can cut or override the low side based on current-sense events that an analog front end reports as digital flags. When the over-limit flag rises, a one-shot switches every low-side gate off for a programmed number of clock cycles. Conduction then resumes. The one-shot cannot be retriggered while it runs. A leading-edge blanking window after each low-side turn-on masks the over-limit flag, so that switching spikes do not trip it.

A separate hard-overcurrent latch turns the low side off when the high-threshold flag is seen. It keeps the low side off until the release flag reports that the current has fallen. For dynamic braking, an active-low brake request forces every low-side gate on and every high-side gate off. The request is only accepted while the power-disable input is asserted. Power-disable alone turns every gate off. The output priority, from highest to lowest, is:

1. brake
2. power-disable
3. hard-overcurrent lockout
4. off-time
5. sequencer pattern

The one-shot state machine has three states:
- `OS_ARMED` waits for an event. Its transitions are *arm-to-blank* (on a low-side turn-on with a non-zero blank count) and *arm-to-off* (on a rising over-limit flag).
- `OS_BLANK` masks the flag. Its transition is *blank-expire*, back to `OS_ARMED`.
- `OS_OFF` holds the low side off. Its transition is *off-expire*, back to `OS_ARMED`.

The latch state machine has two states, `OC_RUN` and `OC_LOCK`. Its transitions are *trip* (`OC_RUN` to `OC_LOCK` when `oc_high` is seen) and *release* (`OC_LOCK` to `OC_RUN` when `oc_clear` is high and `oc_high` is low).

The gate selector picks one of four modes every cycle:
- `GM_NORMAL`
- `GM_LOWOFF`
- `GM_KILL`
- `GM_BRAKE`

Top module: `offtime_current_limiter`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are 0. After reset is released with no events pending, `lo_gate` equals `seq_lo` and `hi_gate` equals `seq_hi` in the same cycle.
- R2: With no current event, no brake and no disable, both gate buses follow the sequencer inputs combinationally, for any pattern.
- R3: A rising edge of `over_limit` sampled at a clock edge while the one-shot is armed and not blanking makes `lo_gate` 3'b000 starting right after that edge. The low side stays off for `off_cycles` cycles and then returns to `seq_lo`. `hi_gate` keeps following `seq_hi` meanwhile.
- R4: An `off_cycles` value of 0 gives an off interval of exactly one cycle.
- R5: A new rising edge of `over_limit` during the off interval is ignored. The interval ends on its original schedule.
- R6: Only a rising edge trips the one-shot. An `over_limit` flag held high after the off interval ends causes no further off interval.
- R7: A low-side turn-on is any `lo_gate` bit changing from 0 to 1. For a non-zero `blank_cycles` value B, the clock edge that first sees the turn-on and the next B edges ignore `over_limit`. A rising edge sampled at the following edge trips normally.
- R8: With `blank_cycles` equal to 0, no blanking applies. A rising edge sampled at the edge that sees a turn-on trips the one-shot.
- R9: `oc_high` high at a clock edge forces `lo_gate` to 3'b000 from just after that edge. The lockout persists after `oc_high` falls until release. `hi_gate` keeps following `seq_hi`.
- R10: The lockout is released at the first edge that samples `oc_clear` high and `oc_high` low. `oc_clear` sampled together with `oc_high` high has no effect.
- R11: With `drive_disable` high and `brake_n` low, `lo_gate` is 3'b111 and `hi_gate` is 3'b000. This takes priority over the lockout and the off-time.
- R12: `brake_n` low while `drive_disable` is low has no effect: the outputs follow the sequencer.
- R13: `drive_disable` high with `brake_n` high makes all six gate outputs 0. Releasing it restores the sequencer pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_lo | input | PHASES | Low-side enables from the commutation sequencer |
| seq_hi | input | PHASES | High-side enables from the commutation sequencer |
| over_limit | input | 1 | Current-sense over-limit flag (PWM threshold) |
| oc_high | input | 1 | Hard overcurrent flag (upper threshold) |
| oc_clear | input | 1 | Current-below-release-threshold flag |
| brake_n | input | 1 | Active-low brake request |
| drive_disable | input | 1 | Power-disable, active high |
| off_cycles | input | OFF_W | Off-time length in clock cycles (0 is treated as 1) |
| blank_cycles | input | BLANK_W | Leading-edge blanking length after a low-side turn-on |
| lo_gate | output | PHASES | Low-side gate enables |
| hi_gate | output | PHASES | High-side gate enables |

## Verification
Some properties are checked on every cycle. These are the brake and disable output overrides, the fact that brake is ignored without disable, and the one-shot staying in its off state while its counter is non-zero. The one-shot never moves from blanking straight to off. The lockout latch is checked to set, hold and release on its flags. Exact off-interval lengths, the boundary edge where blanking ends, zero-length configurations and the order in which a stimulus sequence plays out are shown only by the bench's directed scenarios. Each of these samples the gate outputs at computed cycles.

// File: rtl/clim_pkg.sv
`timescale 1ns/1ps
package clim_pkg;

    typedef enum logic [1:0] {
        OS_ARMED = 2'd0,
        OS_BLANK = 2'd1,
        OS_OFF   = 2'd2
    } os_state_t;

    typedef enum logic {
        OC_RUN  = 1'b0,
        OC_LOCK = 1'b1
    } oc_state_t;

    typedef enum logic [1:0] {
        GM_NORMAL = 2'd0,
        GM_LOWOFF = 2'd1,
        GM_KILL   = 2'd2,
        GM_BRAKE  = 2'd3
    } gate_mode_t;

endpackage

// File: rtl/clim_oneshot.sv
`timescale 1ns/1ps
module clim_oneshot
    import clim_pkg::*;
#(
    parameter int PHASES  = 3,
    parameter int OFF_W   = 8,
    parameter int BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               over_limit,
    input  logic [PHASES-1:0]  lo_applied,
    input  logic [OFF_W-1:0]   off_cycles,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               off_active
);

    localparam int CNT_W = (OFF_W > BLANK_W) ? OFF_W : BLANK_W;

    os_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              ol_q;
    logic [PHASES-1:0] lo_q;
    logic              rise, turn_on;
    logic [CNT_W-1:0]  off_load, blank_load;

    assign rise       = over_limit & ~ol_q;
    assign turn_on    = |(lo_applied & ~lo_q);
    assign off_load   = (off_cycles == '0) ? '0 : (CNT_W'(off_cycles) - CNT_W'(1));
    assign blank_load = CNT_W'(blank_cycles) - CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OS_ARMED;
            cnt   <= '0;
            ol_q  <= 1'b0;
            lo_q  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            ol_q  <= over_limit;
            lo_q  <= lo_applied;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            OS_ARMED: begin
                if (turn_on && (blank_cycles != '0)) begin
                    state_nx = OS_BLANK;          // arm-to-blank
                    cnt_nx   = blank_load;
                end else if (rise) begin
                    state_nx = OS_OFF;            // arm-to-off
                    cnt_nx   = off_load;
                end
            end
            OS_BLANK: begin
                if (cnt == '0) state_nx = OS_ARMED; // blank-expire
                else           cnt_nx   = cnt - CNT_W'(1);
            end
            OS_OFF: begin
                if (cnt == '0) state_nx = OS_ARMED; // off-expire
                else           cnt_nx   = cnt - CNT_W'(1);
            end
            default: begin
                state_nx = OS_ARMED;
                cnt_nx   = '0;
            end
        endcase
    end

    // output
    always_comb begin
        off_active = (state == OS_OFF);
    end

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_OFF && cnt != '0) |=> (state == OS_OFF));

    // R3
    trip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_ARMED && rise && !(turn_on && blank_cycles != '0)) |=> off_active);

    // R7
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_BLANK) |=> (state != OS_OFF));

endmodule

// File: rtl/clim_oc_latch.sv
`timescale 1ns/1ps
module clim_oc_latch
    import clim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oc_high,
    input  logic oc_clear,
    output logic oc_locked
);

    oc_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OC_RUN;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            OC_RUN:  if (oc_high)               state_nx = OC_LOCK; // trip
            OC_LOCK: if (oc_clear && !oc_high)  state_nx = OC_RUN;  // release
            default:                            state_nx = OC_RUN;
        endcase
    end

    // output
    always_comb begin
        oc_locked = (state == OC_LOCK);
    end

    // R9
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_high |=> oc_locked);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_locked && !oc_clear) |=> oc_locked);

    // R10
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_locked && oc_clear && !oc_high) |=> !oc_locked);

endmodule

// File: rtl/clim_gate_select.sv
`timescale 1ns/1ps
module clim_gate_select
    import clim_pkg::*;
#(
    parameter int PHASES = 3
) (
    input  logic              rst_n,
    input  logic              brake_n,
    input  logic              drive_disable,
    input  logic              oc_locked,
    input  logic              off_active,
    input  logic [PHASES-1:0] seq_lo,
    input  logic [PHASES-1:0] seq_hi,
    output logic [PHASES-1:0] lo_gate,
    output logic [PHASES-1:0] hi_gate
);

    gate_mode_t mode;

    always_comb begin
        if (!rst_n)                        mode = GM_KILL;
        else if (drive_disable && !brake_n) mode = GM_BRAKE;
        else if (drive_disable)            mode = GM_KILL;
        else if (oc_locked || off_active)  mode = GM_LOWOFF;
        else                               mode = GM_NORMAL;
    end

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        always_comb begin
            unique case (mode)
                GM_NORMAL: begin lo_gate[ph] = seq_lo[ph]; hi_gate[ph] = seq_hi[ph]; end
                GM_LOWOFF: begin lo_gate[ph] = 1'b0;       hi_gate[ph] = seq_hi[ph]; end
                GM_BRAKE:  begin lo_gate[ph] = 1'b1;       hi_gate[ph] = 1'b0;       end
                default:   begin lo_gate[ph] = 1'b0;       hi_gate[ph] = 1'b0;       end
            endcase
        end
    end

endmodule

// File: rtl/offtime_current_limiter.sv
`timescale 1ns/1ps
module offtime_current_limiter #(
    parameter int PHASES  = 3,
    parameter int OFF_W   = 8,
    parameter int BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASES-1:0]  seq_lo,
    input  logic [PHASES-1:0]  seq_hi,
    input  logic               over_limit,
    input  logic               oc_high,
    input  logic               oc_clear,
    input  logic               brake_n,
    input  logic               drive_disable,
    input  logic [OFF_W-1:0]   off_cycles,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic [PHASES-1:0]  lo_gate,
    output logic [PHASES-1:0]  hi_gate
);

    logic off_active;
    logic oc_locked;

    clim_oneshot #(
        .PHASES (PHASES),
        .OFF_W  (OFF_W),
        .BLANK_W(BLANK_W)
    ) oneshot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .over_limit  (over_limit),
        .lo_applied  (lo_gate),
        .off_cycles  (off_cycles),
        .blank_cycles(blank_cycles),
        .off_active  (off_active)
    );

    clim_oc_latch oc_latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc_high  (oc_high),
        .oc_clear (oc_clear),
        .oc_locked(oc_locked)
    );

    clim_gate_select #(
        .PHASES(PHASES)
    ) gate_sel_i (
        .rst_n        (rst_n),
        .brake_n      (brake_n),
        .drive_disable(drive_disable),
        .oc_locked    (oc_locked),
        .off_active   (off_active),
        .seq_lo       (seq_lo),
        .seq_hi       (seq_hi),
        .lo_gate      (lo_gate),
        .hi_gate      (hi_gate)
    );

    // R11
    brake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_disable && !brake_n) |-> (lo_gate == '1 && hi_gate == '0));

    // R13
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_disable && brake_n) |-> (lo_gate == '0 && hi_gate == '0));

    // R12
    brake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_disable && !brake_n) |-> (hi_gate == seq_hi));

endmodule

// File: tb/offtime_current_limiter_tb_top.sv
`timescale 1ns/1ps
module offtime_current_limiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] seq_lo, seq_hi;
    logic       over_limit, oc_high, oc_clear, brake_n, drive_disable;
    logic [7:0] off_cycles;
    logic [3:0] blank_cycles;
    logic [2:0] lo_gate, hi_gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    offtime_current_limiter dut_i (
        .clk(clk), .rst_n(rst_n), .seq_lo(seq_lo), .seq_hi(seq_hi),
        .over_limit(over_limit), .oc_high(oc_high), .oc_clear(oc_clear),
        .brake_n(brake_n), .drive_disable(drive_disable),
        .off_cycles(off_cycles), .blank_cycles(blank_cycles),
        .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    task automatic chk(input string tag, input string what, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic nstep();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; seq_lo = 3'b001; seq_hi = 3'b010;
        over_limit = 0; oc_high = 0; oc_clear = 0; brake_n = 1; drive_disable = 0;
        off_cycles = 8'd4; blank_cycles = 4'd0;
        #1;
        chk("R1", "lo in reset", lo_gate, 3'b000);
        chk("R1", "hi in reset", hi_gate, 3'b000);
        repeat (3) nstep();
        rst_n = 1'b1; settle();
        chk("R1", "lo after reset", lo_gate, 3'b001);
        chk("R1", "hi after reset", hi_gate, 3'b010);
    endtask

    task automatic t_pass();
        nstep(); seq_lo = 3'b010; seq_hi = 3'b100; settle();
        chk("R2", "lo pattern a", lo_gate, 3'b010);
        chk("R2", "hi pattern a", hi_gate, 3'b100);
        nstep(); seq_lo = 3'b100; seq_hi = 3'b001; settle();
        chk("R2", "lo pattern b", lo_gate, 3'b100);
        chk("R2", "hi pattern b", hi_gate, 3'b001);
        nstep(); seq_lo = 3'b001; seq_hi = 3'b010; settle();
        chk("R2", "lo pattern c", lo_gate, 3'b001);
        repeat (2) nstep();
    endtask

    task automatic t_offtime();
        off_cycles = 8'd4;
        nstep(); over_limit = 1; settle();
        chk("R3", "lo before edge", lo_gate, 3'b001);
        for (int k = 1; k <= 4; k++) begin
            nstep(); settle();
            chk("R3", "lo during off", lo_gate, 3'b000);
            chk("R3", "hi during off", hi_gate, 3'b010);
            over_limit = 0;
        end
        nstep(); settle();
        chk("R3", "lo resumes", lo_gate, 3'b001);
        repeat (2) nstep();
    endtask

    task automatic t_zero();
        off_cycles = 8'd0;
        nstep(); over_limit = 1;
        nstep(); settle();
        chk("R4", "lo off one cycle", lo_gate, 3'b000);
        over_limit = 0;
        nstep(); settle();
        chk("R4", "lo back after one", lo_gate, 3'b001);
        repeat (2) nstep();
    endtask

    task automatic t_noretrig();
        off_cycles = 8'd6;
        nstep(); over_limit = 1;
        for (int k = 1; k <= 6; k++) begin
            nstep(); settle();
            chk("R5", "lo during off", lo_gate, 3'b000);
            if (k == 1) over_limit = 0;
            if (k == 2) over_limit = 1;
        end
        nstep(); settle();
        chk("R5", "off ends on schedule", lo_gate, 3'b001);
        over_limit = 0;
        repeat (2) nstep();
    endtask

    task automatic t_level();
        off_cycles = 8'd3;
        nstep(); over_limit = 1;
        repeat (3) nstep();
        for (int k = 0; k < 4; k++) begin
            nstep(); settle();
            chk("R6", "held flag no retrip", lo_gate, 3'b001);
        end
        over_limit = 0;
        repeat (2) nstep();
    endtask

    task automatic t_blank();
        off_cycles = 8'd2; blank_cycles = 4'd3;
        nstep(); seq_lo = 3'b010; settle();
        chk("R7", "turn-on visible", lo_gate, 3'b010);
        nstep(); over_limit = 1;
        nstep(); settle();
        chk("R7", "rise masked early", lo_gate, 3'b010);
        over_limit = 0;
        nstep(); over_limit = 1;
        nstep(); settle();
        chk("R7", "rise masked last edge", lo_gate, 3'b010);
        over_limit = 0;
        nstep(); over_limit = 1;
        nstep(); settle();
        chk("R7", "rise after window trips", lo_gate, 3'b000);
        over_limit = 0;
        blank_cycles = 4'd0;
        repeat (6) nstep();
        settle();
        chk("R7", "lo restored", lo_gate, 3'b010);
    endtask

    task automatic t_blank0();
        off_cycles = 8'd2; blank_cycles = 4'd0;
        nstep(); seq_lo = 3'b100; over_limit = 1;
        nstep(); settle();
        chk("R8", "no blanking trips", lo_gate, 3'b000);
        over_limit = 0;
        repeat (3) nstep();
        settle();
        chk("R8", "lo restored", lo_gate, 3'b100);
    endtask

    task automatic t_oc();
        nstep(); oc_high = 1;
        nstep(); settle();
        chk("R9", "lo locked", lo_gate, 3'b000);
        chk("R9", "hi follows seq", hi_gate, 3'b010);
        nstep(); oc_high = 0;
        nstep(); settle();
        chk("R9", "lock persists", lo_gate, 3'b000);
        oc_clear = 1; oc_high = 1;
        nstep(); settle();
        chk("R10", "clear with high ignored", lo_gate, 3'b000);
        oc_high = 0;
        nstep(); settle();
        chk("R10", "released", lo_gate, 3'b100);
        oc_clear = 0;
        repeat (2) nstep();
    endtask

    task automatic t_brake();
        nstep(); drive_disable = 1; settle();
        chk("R13", "lo disabled", lo_gate, 3'b000);
        chk("R13", "hi disabled", hi_gate, 3'b000);
        nstep(); brake_n = 0; settle();
        chk("R11", "lo braking", lo_gate, 3'b111);
        chk("R11", "hi braking", hi_gate, 3'b000);
        oc_high = 1;
        nstep(); oc_high = 0; settle();
        chk("R11", "brake over lock", lo_gate, 3'b111);
        brake_n = 1; oc_clear = 1;
        nstep(); oc_clear = 0; drive_disable = 0; settle();
        chk("R13", "release lo", lo_gate, 3'b100);
        chk("R13", "release hi", hi_gate, 3'b010);
        repeat (2) nstep();
    endtask

    task automatic t_brake_ignored();
        nstep(); brake_n = 0; settle();
        chk("R12", "lo unaffected", lo_gate, 3'b100);
        chk("R12", "hi unaffected", hi_gate, 3'b010);
        nstep(); settle();
        chk("R12", "lo still unaffected", lo_gate, 3'b100);
        brake_n = 1;
        repeat (2) nstep();
    endtask

    initial begin
        t_reset();
        t_pass();
        t_offtime();
        t_zero();
        t_noretrig();
        t_level();
        t_blank();
        t_blank0();
        t_oc();
        t_brake();
        t_brake_ignored();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule